// File: doc/BRIEF.md
# Phase-Shifted Bridge Gate Sequencer

This block produces fixed-frequency gate commands for an isolated step-down converter. On the input side sit two stacked full bridges of four switches each. On the output side sits a four-switch rectifier, plus one auxiliary switch that ties the secondary to a split output capacitor. A free-running tick counter defines the switching period. Every leg toggles at 50% duty, with a dead interval at the start of each half where both of its switches are off. The rectifier legs lag the input legs by a programmable number of ticks, and that lag is the only control of delivered power.

In full-power mode both input bridges switch in phase, the whole rectifier switches and the auxiliary switch stays off. In low-power mode one input bridge at a time has its two low-side switches held on, which shorts its winding. The shorted bridge swaps on every period, and the first low-power period always shorts bridge 0. In the same mode the rectifier becomes a half bridge: its second leg is off and the auxiliary switch is on.

All settings are sampled only when a new period starts. The period, phase and dead-time counts are saturated to a legal range before use. Gate outputs are registered.

Top module: `bridge_gate_seq`

## Requirements
- R1: While `rst_n` is low all thirteen gate outputs are 0. They also stay 0 through the first clock edge after `rst_n` rises, because that edge only loads the settings.
- R2: The period is 2*H ticks, with H = max(floor(`period_cnt`/2), 2). `inv_gate[0]` rises once per period.
- R3: Each leg's high switch is on for H-D ticks and its low switch for H-D ticks of every period, where D is the leg's dead-time. The two switches of a leg (bit pairs 0/1, 2/3, 4/5, 6/7 of `inv_gate`; 0/1, 2/3 of `rect_gate`) are never on together.
- R4: Within a bridge the second leg (bits 2/3) runs in antiphase to the first leg (bits 0/1). Bit 3 therefore equals bit 0 at all times.
- R5: In full-power mode (`low_power`=0), `inv_gate[7:4]` equals `inv_gate[3:0]`, both rectifier legs switch, and `aux_gate` is 0.
- R6: The rising edge of `rect_gate[0]` follows the rising edge of `inv_gate[0]` by S + Dr - Di ticks, where Di and Dr are the inverter and rectifier dead-times. S is `phase_cnt` saturated to the range 1..H, so a value of 0 becomes 1 and a value above H becomes H.
- R7: In low-power mode the clamped bridge shows the pattern 4'b1010: its low switches are on and its high switches are off. The first low-power period clamps `inv_gate[3:0]`, the next clamps `inv_gate[7:4]`, and the clamp keeps alternating every period while the other bridge switches.
- R8: In low-power mode `rect_gate[3:2]` is 0, `aux_gate` is 1, and `rect_gate[1:0]` switches as a half bridge.
- R9: A change of `low_power`, `period_cnt`, `phase_cnt` or either dead-time in the middle of a period has no effect on the outputs until the next period starts.
- R10: A dead-time count of H or more is saturated to H-1, which leaves each switch on for one tick per half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_cnt | input | PER_W | Requested period length in ticks |
| phase_cnt | input | PER_W | Rectifier lag in ticks |
| dt_inv_cnt | input | DT_W | Inverter dead-time in ticks |
| dt_rect_cnt | input | DT_W | Rectifier dead-time in ticks |
| low_power | input | 1 | 1 selects low-power mode |
| inv_gate | output | 8 | Input bridge gates; bits 3:0 bridge 0, bits 7:4 bridge 1 |
| rect_gate | output | 4 | Rectifier gates; bits 1:0 first leg, bits 3:2 second leg |
| aux_gate | output | 1 | Auxiliary half-bridge switch |

## Verification
Two events can fall on the same edge. One is the period boundary, which latches new settings and flips the clamped bridge. The other is a rectifier edge, which at large phase counts sits right at the boundary, or a mode request made on the boundary's last tick. The bench changes the mode and the settings in mid-period and at high phase counts. Every output is compared each cycle against an independent tick-level model, and the clamp order, rectifier lag and duty counts are measured directly at the pins.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  localparam int CW       = 16;
  localparam int MIN_HALF = 2;
  localparam int N_LEG    = 4;
  localparam int N_INV    = 8;
  localparam int N_RECT   = 4;
  localparam logic [3:0] CLAMP_PAT = 4'b1010;

  typedef logic [CW-1:0] cnt_t;

  function automatic cnt_t sat_half(input cnt_t per);
    cnt_t h;
    h = per >> 1;
    return (h < cnt_t'(MIN_HALF)) ? cnt_t'(MIN_HALF) : h;
  endfunction

  function automatic cnt_t sat_phase(input cnt_t ph, input cnt_t h);
    if (ph == '0) return cnt_t'(1);
    if (ph > h)   return h;
    return ph;
  endfunction

  function automatic cnt_t sat_dt(input cnt_t d, input cnt_t h);
    return (d >= h) ? (h - cnt_t'(1)) : d;
  endfunction

  function automatic cnt_t last_tick(input cnt_t h);
    return (h << 1) - cnt_t'(1);
  endfunction

  // position of tick t inside a leg whose period starts at offset off
  function automatic cnt_t leg_pos(input cnt_t t, input cnt_t off, input cnt_t h);
    return (t >= off) ? (t - off) : (t + (h << 1) - off);
  endfunction

  function automatic logic next_clamp(input logic lp_req, input logic lp_cont,
                                      input logic cur);
    if (!lp_req) return 1'b0;
    if (lp_cont) return ~cur;
    return 1'b0;
  endfunction
endpackage

// File: rtl/bgs_timebase.sv
module bgs_timebase
  import bgs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cnt_t period_in,
  input  cnt_t phase_in,
  input  cnt_t dti_in,
  input  cnt_t dtr_in,
  input  logic lp_in,
  output logic run,
  output cnt_t t_cnt,
  output cnt_t half_q,
  output cnt_t phase_q,
  output cnt_t dti_q,
  output cnt_t dtr_q,
  output logic lp_q,
  output logic clamp2_q,
  output logic period_end
);
  cnt_t half_n;
  logic load;

  assign half_n     = sat_half(period_in);
  assign period_end = run && (t_cnt == last_tick(half_q));
  assign load       = !run || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      t_cnt    <= '0;
      half_q   <= cnt_t'(MIN_HALF);
      phase_q  <= cnt_t'(1);
      dti_q    <= '0;
      dtr_q    <= '0;
      lp_q     <= 1'b0;
      clamp2_q <= 1'b0;
    end else if (load) begin
      run      <= 1'b1;
      t_cnt    <= '0;
      half_q   <= half_n;
      phase_q  <= sat_phase(phase_in, half_n);
      dti_q    <= sat_dt(dti_in, half_n);
      dtr_q    <= sat_dt(dtr_in, half_n);
      lp_q     <= lp_in;
      clamp2_q <= next_clamp(lp_in, run && lp_q, clamp2_q);
    end else begin
      t_cnt <= t_cnt + cnt_t'(1);
    end
  end
endmodule

// File: rtl/bgs_leg.sv
module bgs_leg
  import bgs_pkg::*;
(
  input  cnt_t t_cnt,
  input  cnt_t half,
  input  cnt_t off,
  input  cnt_t dt,
  output logic hi,
  output logic lo
);
  cnt_t u;
  assign u  = leg_pos(t_cnt, off, half);
  assign hi = (u >= dt) && (u < half);
  assign lo = (u >= half + dt);
endmodule

// File: rtl/bgs_gate_map.sv
module bgs_gate_map
  import bgs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              lp,
  input  logic              clamp2,
  input  logic [N_LEG-1:0]  leg_hi,
  input  logic [N_LEG-1:0]  leg_lo,
  output logic [N_INV-1:0]  inv_gate,
  output logic [N_RECT-1:0] rect_gate,
  output logic              aux_gate
);
  logic [3:0] bridge;
  logic [3:0] rect_full;

  assign bridge    = {leg_lo[1], leg_hi[1], leg_lo[0], leg_hi[0]};
  assign rect_full = {leg_lo[3], leg_hi[3], leg_lo[2], leg_hi[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_gate  <= '0;
      rect_gate <= '0;
      aux_gate  <= 1'b0;
    end else if (!run) begin
      inv_gate  <= '0;
      rect_gate <= '0;
      aux_gate  <= 1'b0;
    end else if (lp) begin
      inv_gate  <= clamp2 ? {CLAMP_PAT, bridge} : {bridge, CLAMP_PAT};
      rect_gate <= {2'b00, rect_full[1:0]};
      aux_gate  <= 1'b1;
    end else begin
      inv_gate  <= {bridge, bridge};
      rect_gate <= rect_full;
      aux_gate  <= 1'b0;
    end
  end
endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
  import bgs_pkg::*;
#(
  parameter int PER_W = 12,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_cnt,
  input  logic [PER_W-1:0] phase_cnt,
  input  logic [DT_W-1:0]  dt_inv_cnt,
  input  logic [DT_W-1:0]  dt_rect_cnt,
  input  logic             low_power,
  output logic [7:0]       inv_gate,
  output logic [3:0]       rect_gate,
  output logic             aux_gate
);
  localparam int LEGS_PER_SIDE = N_LEG / 2;

  cnt_t run_t, half_q, phase_q, dti_q, dtr_q;
  logic run, lp_q, clamp2_q, period_end;
  cnt_t leg_off [N_LEG];
  logic [N_LEG-1:0] leg_hi, leg_lo;

  bgs_timebase u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_in (cnt_t'(period_cnt)),
    .phase_in  (cnt_t'(phase_cnt)),
    .dti_in    (cnt_t'(dt_inv_cnt)),
    .dtr_in    (cnt_t'(dt_rect_cnt)),
    .lp_in     (low_power),
    .run       (run),
    .t_cnt     (run_t),
    .half_q    (half_q),
    .phase_q   (phase_q),
    .dti_q     (dti_q),
    .dtr_q     (dtr_q),
    .lp_q      (lp_q),
    .clamp2_q  (clamp2_q),
    .period_end(period_end)
  );

  always_comb begin
    leg_off[0] = '0;
    leg_off[1] = half_q;
    leg_off[2] = phase_q;
    leg_off[3] = phase_q + half_q;
  end

  for (genvar i = 0; i < N_LEG; i++) begin : g_leg
    localparam bit INV_SIDE = (i < LEGS_PER_SIDE);
    bgs_leg u_leg (
      .t_cnt(run_t),
      .half (half_q),
      .off  (leg_off[i]),
      .dt   (INV_SIDE ? dti_q : dtr_q),
      .hi   (leg_hi[i]),
      .lo   (leg_lo[i])
    );
  end

  bgs_gate_map u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .lp       (lp_q),
    .clamp2   (clamp2_q),
    .leg_hi   (leg_hi),
    .leg_lo   (leg_lo),
    .inv_gate (inv_gate),
    .rect_gate(rect_gate),
    .aux_gate (aux_gate)
  );
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker
  import bgs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       period_end,
  input logic       lp_q,
  input logic       lp_sel,
  input logic       clamp2,
  input cnt_t       t_cnt,
  input cnt_t       half_q,
  input cnt_t       phase_q,
  input logic [7:0] inv_gate,
  input logic [3:0] rect_gate,
  input logic       aux_gate
);
  AST_RST_QUIET: assert property (@(negedge clk)
    !rst_n |-> (inv_gate == 8'd0 && rect_gate == 4'd0 && !aux_gate)); // R1

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (t_cnt < (half_q << 1))); // R2

  AST_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_gate[0] && inv_gate[1]) && !(inv_gate[2] && inv_gate[3]) &&
    !(inv_gate[4] && inv_gate[5]) && !(inv_gate[6] && inv_gate[7]) &&
    !(rect_gate[0] && rect_gate[1]) && !(rect_gate[2] && rect_gate[3])); // R3

  AST_FP_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_gate |-> (inv_gate[7:4] == inv_gate[3:0])); // R5

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (phase_q >= cnt_t'(1) && phase_q <= half_q)); // R6

  AST_CLAMP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !lp_q && lp_sel) |=> !clamp2); // R7

  AST_CLAMP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && lp_q && lp_sel) |=> (clamp2 != $past(clamp2))); // R7

  AST_HALF_RECT: assert property (@(posedge clk) disable iff (!rst_n)
    aux_gate |-> (rect_gate[3:2] == 2'b00)); // R8

  AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !period_end) |=> ($stable(lp_q) && $stable(phase_q) && $stable(half_q))); // R9
endmodule

bind bridge_gate_seq bgs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .period_end(period_end),
  .lp_q      (lp_q),
  .lp_sel    (low_power),
  .clamp2    (clamp2_q),
  .t_cnt     (run_t),
  .half_q    (half_q),
  .phase_q   (phase_q),
  .inv_gate  (inv_gate),
  .rect_gate (rect_gate),
  .aux_gate  (aux_gate)
);

// File: tb/bridge_gate_seq_bench.sv
`timescale 1ns/1ps
module bridge_gate_seq_bench;
  localparam int PER_W = 12;
  localparam int DT_W  = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b1;
  logic [PER_W-1:0] period_cnt = '0;
  logic [PER_W-1:0] phase_cnt = '0;
  logic [DT_W-1:0]  dt_inv_cnt = '0;
  logic [DT_W-1:0]  dt_rect_cnt = '0;
  logic             low_power = 1'b0;
  logic [7:0]       inv_gate;
  logic [3:0]       rect_gate;
  logic             aux_gate;

  bridge_gate_seq #(.PER_W(PER_W), .DT_W(DT_W)) u_bridge_gate_seq (
    .clk(clk), .rst_n(rst_n), .period_cnt(period_cnt), .phase_cnt(phase_cnt),
    .dt_inv_cnt(dt_inv_cnt), .dt_rect_cnt(dt_rect_cnt), .low_power(low_power),
    .inv_gate(inv_gate), .rect_gate(rect_gate), .aux_gate(aux_gate)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wire [12:0] obs = {aux_gate, rect_gate, inv_gate};

  // ---------------- reference model (tick level) ----------------
  bit        m_run, m_lp, m_c2;
  int        m_t, m_h, m_ph, m_di, m_dr;
  logic [12:0] m_g;

  function automatic logic [1:0] ref_leg(int t, int start, int h, int d);
    int u;
    u = (t - start + 2 * h) % (2 * h);
    if (u < d)     return 2'b00;
    if (u < h)     return 2'b01;
    if (u < h + d) return 2'b00;
    return 2'b10;
  endfunction

  function automatic logic [12:0] ref_out(int t, int h, int ph, int di, int dr,
                                          bit lp, bit c2);
    logic [1:0] a, b, c, d;
    logic [3:0] br;
    a = ref_leg(t, 0, h, di);
    b = ref_leg(t, h, h, di);
    c = ref_leg(t, ph, h, dr);
    d = ref_leg(t, ph + h, h, dr);
    br = {b, a};
    if (lp) return {1'b1, 2'b00, c, (c2 ? {4'b1010, br} : {br, 4'b1010})};
    return {1'b0, d, c, br, br};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_t <= 0; m_h <= 2; m_ph <= 1; m_di <= 0; m_dr <= 0;
      m_lp <= 0; m_c2 <= 0; m_g <= '0;
    end else begin
      m_g <= m_run ? ref_out(m_t, m_h, m_ph, m_di, m_dr, m_lp, m_c2) : 13'd0;
      if (!m_run || m_t == 2 * m_h - 1) begin
        int h;
        h = int'(period_cnt) / 2;
        if (h < 2) h = 2;
        m_run <= 1; m_t <= 0; m_h <= h;
        m_ph <= (phase_cnt == 0) ? 1 : ((int'(phase_cnt) > h) ? h : int'(phase_cnt));
        m_di <= (int'(dt_inv_cnt) >= h) ? h - 1 : int'(dt_inv_cnt);
        m_dr <= (int'(dt_rect_cnt) >= h) ? h - 1 : int'(dt_rect_cnt);
        m_c2 <= (low_power && m_run && m_lp) ? !m_c2 : 1'b0;
        m_lp <= low_power;
      end else begin
        m_t <= m_t + 1;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(string req);
    @(negedge clk);
    check(obs === m_g, req, int'(obs), int'(m_g));
  endtask

  task automatic run_cmp(int n, string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic set_cfg(int p, int ph, int di, int dr, bit lp);
    period_cnt = PER_W'(p); phase_cnt = PER_W'(ph);
    dt_inv_cnt = DT_W'(di); dt_rect_cnt = DT_W'(dr); low_power = lp;
  endtask

  task automatic wait_rise(int b, string req);
    bit prev;
    bit seen;
    prev = obs[b];
    seen = 0;
    for (int i = 0; i < 1000 && !seen; i++) begin
      step(req);
      if (!prev && obs[b]) seen = 1;
      prev = obs[b];
    end
    check(seen, req, 0, 1);
  endtask

  // cycles from the current rise of bit a until the next rise of bit b
  task automatic rise_gap(int b, string req, output int n);
    bit prev;
    prev = obs[b];
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      step(req);
      n++;
      if (!prev && obs[b]) break;
      prev = obs[b];
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_start();
    set_cfg(40, 5, 2, 2, 0);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(obs == 13'd0, "R1 held in reset", int'(obs), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(obs == 13'd0, "R1 first edge after release", int'(obs), 0);
    check(obs === m_g, "R1 model", int'(obs), int'(m_g));
  endtask

  task automatic t_full_power();
    int hi_q1, ovl, mis4, mis5, aux_n, n;
    run_cmp(90, "R5 steady compare");
    wait_rise(0, "R2 find rise");
    hi_q1 = 0; ovl = 0; mis4 = 0; mis5 = 0; aux_n = 0;
    for (int i = 0; i < 40; i++) begin
      step("R3 window");
      hi_q1 += int'(obs[0]);
      ovl   += int'(obs[0] && obs[2]);
      mis4  += int'(obs[0] != obs[3]);
      mis5  += int'(obs[3:0] != obs[7:4]);
      aux_n += int'(obs[12]);
    end
    check(hi_q1 == 18, "R3 high-side ticks", hi_q1, 18);
    check(ovl == 0, "R4 antiphase overlap", ovl, 0);
    check(mis4 == 0, "R4 bit3 equals bit0", mis4, 0);
    check(mis5 == 0, "R5 bridges in phase", mis5, 0);
    check(aux_n == 0, "R5 aux off", aux_n, 0);
    wait_rise(0, "R2 sync");
    rise_gap(0, "R2 period", n);
    check(n == 40, "R2 period length", n, 40);
    rise_gap(8, "R6 lag", n);
    check(n == 5, "R6 rectifier lag", n, 5);
  endtask

  task automatic t_phase_sat();
    int n;
    set_cfg(40, 35, 2, 2, 0);
    run_cmp(90, "R6 compare high phase");
    wait_rise(0, "R6 sync");
    rise_gap(8, "R6 lag high", n);
    check(n == 20, "R6 phase saturated to half", n, 20);
    set_cfg(3, 0, 0, 0, 0);
    run_cmp(50, "R2 compare short period");
    wait_rise(0, "R2 sync short");
    rise_gap(0, "R2 short", n);
    check(n == 4, "R2 minimum period", n, 4);
    rise_gap(8, "R6 lag zero", n);
    check(n == 1, "R6 phase zero saturated to one", n, 1);
  endtask

  task automatic t_dt_sat();
    int c1, c9;
    set_cfg(20, 5, 40, 40, 0);
    run_cmp(60, "R10 compare");
    c1 = 0; c9 = 0;
    for (int i = 0; i < 20; i++) begin
      step("R10 window");
      c1 += int'(obs[0]);
      c9 += int'(obs[8]);
    end
    check(c1 == 1, "R10 inverter dead-time saturated", c1, 1);
    check(c9 == 1, "R10 rectifier dead-time saturated", c9, 1);
  endtask

  task automatic t_low_power();
    int mis1, mis2, r34, q9;
    set_cfg(40, 5, 2, 2, 0);
    run_cmp(90, "R9 settle");
    wait_rise(0, "R9 sync");
    low_power = 1'b1;
    run_cmp(3, "R9 mid-period request");
    check(obs[12] == 1'b0, "R9 mode held until boundary", int'(obs[12]), 0);
    wait_rise(12, "R8 aux rise");
    mis1 = int'(obs[3:0] != 4'b1010); r34 = int'(obs[11:10] != 2'b00);
    q9 = int'(obs[8]);
    for (int i = 0; i < 39; i++) begin
      step("R7 first lp period");
      mis1 += int'(obs[3:0] != 4'b1010);
      r34  += int'(obs[11:10] != 2'b00) + int'(!obs[12]);
      q9   += int'(obs[8]);
    end
    check(mis1 == 0, "R7 first period clamps bridge 0", mis1, 0);
    check(r34 == 0, "R8 second rect leg off, aux on", r34, 0);
    check(q9 == 18, "R8 half-bridge leg switches", q9, 18);
    mis2 = 0;
    for (int i = 0; i < 40; i++) begin
      step("R7 second lp period");
      mis2 += int'(obs[7:4] != 4'b1010);
    end
    check(mis2 == 0, "R7 second period clamps bridge 1", mis2, 0);
    step("R7 third lp period");
    check(obs[3:0] == 4'b1010, "R7 clamp returns to bridge 0", int'(obs[3:0]), 10);
    low_power = 1'b0;
    run_cmp(100, "R5 back to full power");
    check(obs[12] == 1'b0, "R5 aux off after exit", int'(obs[12]), 0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(obs == 13'd0, "R1 mid-run reset", int'(obs), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_cmp(50, "R1 restart compare");
  endtask

  initial begin
    t_reset_start();
    t_full_power();
    t_phase_sat();
    t_dt_sat();
    t_low_power();
    t_reset_mid();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule